// File: doc/BRIEF.md
# Reference Clock Validity Monitor

This block decides, in the local crystal-derived clock domain, whether an external reference clock can be trusted. A reference is picked from one of two pins. Its rising edges are brought into the local domain and counted over a fixed gate of local cycles. The count is scaled by the chosen reference-to-crystal ratio and compared with a lower and an upper limit. The outcome drives a validity flag and a hold request. While the hold request is active, an external tuning code keeps its last value. A missing-edge timer drops the flag quickly when the reference stops. The flag rises again only after a complete in-range gate that starts at the first edge after the failure. The gate is much longer than the drop time, so dropping is fast and recovering is slow.

The ratio select has one code that turns the monitor off. In that mode the selected reference goes straight to a pass-through output, and the tuning loop is held.

Top module: `ref_failsafe_mon`

## Requirements
- R1: `ref_sel` = 1 monitors `ref_a` and `ref_sel` = 0 monitors `ref_b`. Stopping or changing the pin that is not selected has no effect on `ref_ok`.
- R2: `ratio_sel` sets the nominal reference period in `clk` cycles. 2'b01 gives 2*XTAL_CYC (reference at half the crystal rate), 2'b11 gives XTAL_CYC (equal rates) and 2'b10 gives XTAL_CYC/2 (twice the crystal rate). The gate edge count is multiplied by 2 for 01, kept as is for 11, and halved with the remainder dropped for 10.
- R3: `ratio_sel` = 2'b00 is bypass. `bypass` is 1, `ref_ok` is held at 0, `tune_hold` is 1, and `byp_clk` follows the selected reference. For any other code, `bypass` is 0 and `byp_clk` is 0.
- R4: A gate is GATE_CYC cycles long. It opens at the first accepted edge, and further gates follow back to back. At the end of each gate, `ref_ok` becomes 1 if the scaled count lies in [LO_LIM, HI_LIM] and 0 otherwise.
- R5: The stall limit is two nominal periods: 4*XTAL_CYC for 01, 2*XTAL_CYC for 11 and XTAL_CYC for 10. Take the first `clk` edge that samples the last reference rise as edge 1. If no further rise comes, `ref_ok` falls at edge limit+3.
- R6: After a failure, take the first `clk` edge that samples a reference rise as edge 1. If the gate count is in range, `ref_ok` rises at edge GATE_CYC+2 and not sooner. GATE_CYC covers at least 12 nominal periods for every ratio.
- R7: A change of `ref_sel` or `ratio_sel` drops `ref_ok` on the next edge and restarts measurement. Reference edges are ignored for the three cycles that follow.
- R8: During and after reset, `ref_ok` is 0 and `tune_hold` is 1 until the first qualification completes.
- R9: `tune_hold` is always the complement of `ref_ok`, so the tuning code is frozen whenever the reference is not valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local crystal-derived clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_a | input | 1 | First reference clock |
| ref_b | input | 1 | Second reference clock |
| ref_sel | input | 1 | Reference choice: 1 selects ref_a, 0 selects ref_b |
| ratio_sel | input | 2 | Reference-to-crystal ratio code, 00 = bypass |
| ref_ok | output | 1 | Reference valid flag |
| tune_hold | output | 1 | Request to freeze the external tuning code |
| bypass | output | 1 | High while the monitor is in bypass |
| byp_clk | output | 1 | Selected reference passed through in bypass |

## Verification
A reference rise that lands just after a `clk` edge is sampled by the next edge. It reaches the gate logic two edges later, after the two synchroniser flops. This fixes the result times: qualification is due GATE_CYC+2 edges after that first sampling edge, a stall is flagged stall-limit+3 edges after it, and a selection change shows up one edge later. The bench drives every reference transition 1 ns after an edge and counts edges. It samples each result at the falling edge of the cycle where it is due, and also at the falling edge of the cycle before, where the old value must still hold. The ratio and period sweep computes each expected gate count arithmetically from the period, as floor((GATE_CYC-1)/period)+1, before scaling.

// File: rtl/ref_failsafe_mon.sv
`timescale 1ns/1ps
module ref_failsafe_mon #(
  parameter int XTAL_CYC = 8,
  parameter int GATE_CYC = 256,
  parameter int LO_LIM   = 31,
  parameter int HI_LIM   = 33
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_a,
  input  logic       ref_b,
  input  logic       ref_sel,
  input  logic [1:0] ratio_sel,
  output logic       ref_ok,
  output logic       tune_hold,
  output logic       bypass,
  output logic       byp_clk
);
  localparam int GW = $clog2(GATE_CYC + 1);
  localparam int SW = GW + 2;
  localparam int TW = $clog2(4 * XTAL_CYC + 1);

  typedef enum logic {ST_ARM, ST_RUN} st_t;
  st_t st;

  logic [2:0]    sy;
  logic          sel_q;
  logic [1:0]    rat_q;
  logic [1:0]    mask;
  logic [GW-1:0] gcnt, ecnt;
  logic [TW-1:0] gap, tmo_lim;
  logic [SW-1:0] tot, scaled;
  logic          ref_mux, edge_ok, cfg_chg, gate_end, stall, in_win;

  assign ref_mux   = ref_sel ? ref_a : ref_b;
  assign bypass    = (ratio_sel == 2'b00);
  assign byp_clk   = bypass & ref_mux;
  assign tune_hold = ~ref_ok;
  assign edge_ok   = sy[1] & ~sy[2] & (mask == 2'd0);
  assign cfg_chg   = (ref_sel != sel_q) | (ratio_sel != rat_q);
  assign gate_end  = (gcnt == GW'(GATE_CYC - 1));
  assign stall     = (st == ST_RUN) & ~edge_ok & (gap == tmo_lim - 1'b1);
  assign tot       = SW'(ecnt) + SW'(edge_ok);
  assign in_win    = (scaled >= SW'(LO_LIM)) && (scaled <= SW'(HI_LIM));

  always_comb begin
    case (ratio_sel)
      2'b01: begin tmo_lim = TW'(4 * XTAL_CYC); scaled = tot << 1; end
      2'b10: begin tmo_lim = TW'(XTAL_CYC);     scaled = tot >> 1; end
      default: begin tmo_lim = TW'(2 * XTAL_CYC); scaled = tot; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy    <= '0;
      sel_q <= 1'b0;
      rat_q <= 2'b00;
    end else begin
      sy    <= {sy[1:0], ref_mux};
      sel_q <= ref_sel;
      rat_q <= ratio_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_ARM;
      ref_ok <= 1'b0;
      gcnt   <= '0;
      ecnt   <= '0;
      gap    <= '0;
      mask   <= 2'd0;
    end else if (bypass || cfg_chg) begin
      st     <= ST_ARM;
      ref_ok <= 1'b0;
      gcnt   <= '0;
      ecnt   <= '0;
      gap    <= '0;
      mask   <= 2'd3;
    end else begin
      if (mask != 2'd0) mask <= mask - 2'd1;
      if (edge_ok) gap <= '0;
      else if (gap != tmo_lim) gap <= gap + 1'b1;
      case (st)
        ST_ARM: if (edge_ok) begin
          st   <= ST_RUN;
          gcnt <= GW'(1);
          ecnt <= GW'(1);
        end
        default: if (stall) begin
          st     <= ST_ARM;
          ref_ok <= 1'b0;
          gcnt   <= '0;
          ecnt   <= '0;
        end else if (gate_end) begin
          ref_ok <= in_win;
          gcnt   <= '0;
          ecnt   <= '0;
        end else begin
          gcnt <= gcnt + 1'b1;
          ecnt <= ecnt + GW'(edge_ok);
        end
      endcase
    end
  end
endmodule

module ref_failsafe_chk #(
  parameter int XTAL_CYC = 8,
  parameter int GATE_CYC = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_a,
  input logic       ref_b,
  input logic       ref_sel,
  input logic [1:0] ratio_sel,
  input logic       ref_ok,
  input logic       bypass
);
  logic        mux, mux_q, sel_q;
  logic [1:0]  rat_q;
  int unsigned since, lowc, tmo;

  assign mux = ref_sel ? ref_a : ref_b;

  always_comb begin
    case (ratio_sel)
      2'b01:   tmo = 4 * XTAL_CYC;
      2'b10:   tmo = XTAL_CYC;
      default: tmo = 2 * XTAL_CYC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_q <= 1'b0;
      sel_q <= 1'b0;
      rat_q <= 2'b00;
      since <= 0;
      lowc  <= 0;
    end else begin
      mux_q <= mux;
      sel_q <= ref_sel;
      rat_q <= ratio_sel;
      if ((mux && !mux_q) || ref_sel != sel_q || ratio_sel != rat_q) since <= 0;
      else if (since < 65535) since <= since + 1;
      if (ref_ok) lowc <= 0;
      else if (lowc < 65535) lowc <= lowc + 1;
    end
  end

  // R3
  bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && $past(bypass)) |-> !ref_ok);

  // R7
  cfg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_sel != $past(ref_sel) || ratio_sel != $past(ratio_sel)) |=> !ref_ok);

  // R5
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since > tmo + 2) |-> !ref_ok);

  // R6
  requal_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ref_ok) |-> (lowc >= GATE_CYC - 1));
endmodule

bind ref_failsafe_mon ref_failsafe_chk #(.XTAL_CYC(XTAL_CYC), .GATE_CYC(GATE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_sel(ref_sel),
  .ratio_sel(ratio_sel), .ref_ok(ref_ok), .bypass(bypass)
);

// File: tb/sim_ref_failsafe_mon.sv
`timescale 1ns/1ps
module sim_ref_failsafe_mon;
  localparam int XC = 8, GATE = 256, LO = 31, HI = 33;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ref_a = 1'b0, ref_b = 1'b0, ref_sel = 1'b1;
  logic [1:0] ratio_sel = 2'b11;
  logic ref_ok, tune_hold, bypass, byp_clk;

  int nchk = 0, nerr = 0, cyc = 0;
  bit run_a = 0, run_b = 0;
  int per_a = 8, per_b = 8, cnt_a = 0, cnt_b = 0, last_a = 0, last_b = 0;

  ref_failsafe_mon #(.XTAL_CYC(XC), .GATE_CYC(GATE), .LO_LIM(LO), .HI_LIM(HI)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_a(ref_a), .ref_b(ref_b), .ref_sel(ref_sel),
    .ratio_sel(ratio_sel), .ref_ok(ref_ok), .tune_hold(tune_hold),
    .bypass(bypass), .byp_clk(byp_clk));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (run_a) begin
      if (cnt_a == 0) last_a = cyc;
      ref_a = (cnt_a < per_a / 2);
      cnt_a = (cnt_a + 1) % per_a;
    end else begin
      ref_a = 1'b0; cnt_a = 0;
    end
    if (run_b) begin
      if (cnt_b == 0) last_b = cyc;
      ref_b = (cnt_b < per_b / 2);
      cnt_b = (cnt_b + 1) % per_b;
    end else begin
      ref_b = 1'b0; cnt_b = 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_cyc(int m);
    while (cyc < m) @(negedge clk);
  endtask

  function automatic bit exp_pass(logic [1:0] r, int p);
    int n, s;
    n = (GATE - 1) / p + 1;
    s = (r == 2'b01) ? 2 * n : (r == 2'b10) ? n / 2 : n;
    return (s >= LO) && (s <= HI);
  endfunction

  function automatic int nom_per(logic [1:0] r);
    return (r == 2'b01) ? 2 * XC : (r == 2'b10) ? XC / 2 : XC;
  endfunction

  task automatic run_case(logic [1:0] r, int p, bit do_tmo);
    int rise, tmo, lr;
    bit e;
    run_a = 0; run_b = 0; ref_sel = 1'b1; ratio_sel = r;
    to_cyc(cyc + 40);
    per_a = p; run_a = 1; rise = cyc + 1;
    e = exp_pass(r, p);
    if (e) begin
      to_cyc(rise + GATE + 1);
      chk("R6 no early qualify", ref_ok, 0);
      to_cyc(rise + GATE + 2);
      chk("R2/R4 in-range qualify", ref_ok, 1);
      chk("R9 hold released", tune_hold, 0);
    end else begin
      to_cyc(rise + GATE + 2);
      chk("R2/R4 out-of-range gate 1", ref_ok, 0);
      to_cyc(rise + 2 * GATE + 2);
      chk("R4 out-of-range gate 2", ref_ok, 0);
      chk("R9 hold kept", tune_hold, 1);
    end
    if (do_tmo && e) begin
      run_a = 0;
      @(negedge clk);
      lr = last_a;
      tmo = 2 * nom_per(r);
      to_cyc(lr + 2 + tmo);
      chk("R5 flag before stall limit", ref_ok, 1);
      to_cyc(lr + 3 + tmo);
      chk("R5 flag at stall limit", ref_ok, 0);
      chk("R9 hold on stall", tune_hold, 1);
    end
  endtask

  initial begin
    #(200000 * 5.0);
    nerr++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    int m, rise;
    logic [1:0] rs;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R8 reset flag", ref_ok, 0);
    chk("R8 reset hold", tune_hold, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 flag after reset", ref_ok, 0);
    chk("R8 hold after reset", tune_hold, 1);
    chk("R3 no bypass", bypass, 0);

    for (int k = 0; k < 3; k++) begin
      rs = (k == 0) ? 2'b01 : (k == 1) ? 2'b11 : 2'b10;
      for (int d = -2; d <= 2; d++) run_case(rs, nom_per(rs) + d, d == 0);
    end

    // R1 / R7: switch to second pin while qualified
    run_case(2'b11, 8, 0);
    per_b = 8; run_b = 1;
    to_cyc(cyc + 3);
    ref_sel = 1'b0; m = cyc;
    to_cyc(m + 1);
    chk("R7 flag drops on select change", ref_ok, 0);
    run_a = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R3 pass-through idle", byp_clk, 0);
    end
    to_cyc(m + GATE + 20);
    chk("R1 second pin qualifies", ref_ok, 1);
    to_cyc(cyc + 100);
    chk("R1 unselected pin stopped", ref_ok, 1);
    ratio_sel = 2'b01; m = cyc;
    to_cyc(m + 1);
    chk("R7 flag drops on ratio change", ref_ok, 0);
    to_cyc(m + 2 * GATE + 30);
    chk("R2 wrong ratio never qualifies", ref_ok, 0);

    // R4: drift out of range while qualified
    run_b = 0; ratio_sel = 2'b11; ref_sel = 1'b1;
    to_cyc(cyc + 40);
    per_a = 8; run_a = 1; rise = cyc + 1;
    to_cyc(rise + GATE + 2);
    chk("R4 qualify before drift", ref_ok, 1);
    per_a = 10;
    to_cyc(rise + 2 * GATE + 1);
    chk("R4 flag held until gate end", ref_ok, 1);
    to_cyc(rise + 2 * GATE + 2);
    chk("R4 drop at gate end", ref_ok, 0);

    // R3: bypass
    ratio_sel = 2'b00; per_a = 8;
    to_cyc(cyc + 3);
    chk("R3 bypass flag", bypass, 1);
    chk("R3 bypass ok low", ref_ok, 0);
    chk("R3 bypass hold", tune_hold, 1);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      chk("R3 pass-through first pin", byp_clk, ref_a);
    end
    ref_sel = 1'b0; run_b = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R3 pass-through second pin", byp_clk, ref_b);
    end
    ref_sel = 1'b1;
    to_cyc(cyc + GATE + 50);
    chk("R3 no qualify in bypass", ref_ok, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule